// File: doc/BRIEF.md
# Programmable Trigger Pulse Delay

This block emits one output pulse a programmed number of clock cycles after each rising edge seen on an external trigger input. A host sets the delay by writing a wide delay word one byte at a time: the byte value sits on an 8-bit data bus, one select line per byte picks which byte of the word is written, and a load strobe qualifies the write.

The trigger is first resynchronised by a two-flop chain. Its rising edge then becomes a single-cycle start pulse, which raises a busy flag and copies the current delay word into the sequencer. A delay counter runs until it matches the copied value. A width counter then holds the output high for a fixed number of cycles. Both counters return to zero, busy drops, and the block waits for the next trigger edge. Any trigger edge that arrives while busy is high is dropped. Software may rewrite the delay word during a sequence, and the new value applies only to the next trigger.

Top module: `trig_delay_unit`

## Requirements
- R1: When a rising trigger level is first sampled at clock edge E0 and the captured delay is D, pulse_out rises at edge E0+2+D. The synchroniser and the start pulse account for the fixed offset of two cycles.
- R2: busy is low up to edge E0+1. It is high from edge E0+2 and falls at the same edge at which pulse_out falls.
- R3: pulse_out stays high for exactly PULSE_W clock cycles (default 4) in every sequence.
- R4: A delay word of zero gives the minimum latency: pulse_out rises at edge E0+2.
- R5: The delay word is 24 bits wide. byte_sel has 3 bits, and bit i selects byte i: bit 0 writes word[7:0], bit 1 writes word[15:8], bit 2 writes word[23:16]. At each rising clock edge where load_stb is 1, every selected byte takes the value of bus_data.
- R6: While load_stb is 0, neither bus_data nor byte_sel changes the delay word.
- R7: A trigger rising edge that is sampled while busy is high starts no sequence. No second pulse follows the sequence in progress.
- R8: The delay word is copied at the start of a sequence. A write made while busy is high changes only the following sequence.
- R9: After reset, pulse_out and busy are 0 and the delay word is zero.
- R10: A trigger held high produces only one sequence. Only the rising edge starts the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | External trigger level |
| bus_data | input | 8 | Byte value for delay word writes |
| load_stb | input | 1 | Write qualifier, active high |
| byte_sel | input | 3 | One-hot byte selects: low, middle, high |
| pulse_out | output | 1 | Delayed output pulse |
| busy | output | 1 | A delay sequence is in progress |

## Verification
The bench measures latency from the first sampled trigger edge across zero, small, byte-boundary, middle-byte and high-byte delays. A design with an off-by-one in the delay compare, or a missing synchroniser stage, shows a latency shifted by one cycle. A retrigger pulse is driven in the middle of a delay, and the trigger is then held high afterwards. A design that detects levels instead of edges, or re-arms while busy, gives a second pulse. A byte is also written in the middle of a sequence, and a write is presented with the strobe low. A design that reads the live register, or ignores load_stb, fires at the wrong time in the current or the next sequence.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_FIRE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/tdl_edge_sync.sv
// Resynchronises a level and flags its rising edge for one cycle.
module tdl_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pls
);
   // chain[STAGES] holds the previous synchronised value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   assign rise_pls = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tdl_delay_regs.sv
// Delay word written one byte lane at a time.
module tdl_delay_regs #(
   parameter int DATA_W = 8,
   parameter int DLY_W  = 24,
   localparam int LANES = DLY_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic [LANES-1:0]  lane_sel,
   output logic [DLY_W-1:0]  word
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DATA_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    lane_q <= '0;
         else if (wr_en && lane_sel[i]) lane_q <= wr_data;
      end
      assign word[i*DATA_W +: DATA_W] = lane_q;
   end
endmodule

// File: rtl/tdl_sequencer.sv
// Busy flag plus delay and width counters in series.
module tdl_sequencer
   import tdl_pkg::*;
#(
   parameter int DLY_W   = 24,
   parameter int PULSE_W = 4,
   localparam int WCW    = (PULSE_W > 1) ? $clog2(PULSE_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DLY_W-1:0] dly_value,
   output logic             busy,
   output logic             fire
);
   seq_state_t       state;
   logic [DLY_W-1:0] target;
   logic [DLY_W-1:0] dcnt;
   logic             width_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         target <= '0;
         dcnt   <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  target <= dly_value;
                  if (dly_value == '0) begin
                     state <= SEQ_FIRE;
                  end else begin
                     state <= SEQ_WAIT;
                     dcnt  <= {{(DLY_W-1){1'b0}}, 1'b1};
                  end
               end
            end
            SEQ_WAIT: begin
               if (dcnt == target) begin
                  state <= SEQ_FIRE;
                  dcnt  <= '0;
               end else begin
                  dcnt <= dcnt + 1'b1;
               end
            end
            SEQ_FIRE: begin
               if (width_done) state <= SEQ_IDLE;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   if (PULSE_W > 1) begin : g_wcount
      logic [WCW-1:0] wcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 wcnt <= '0;
         else if (state == SEQ_FIRE) wcnt <= width_done ? '0 : wcnt + 1'b1;
         else                        wcnt <= '0;
      end
      assign width_done = (wcnt == WCW'(PULSE_W - 1));
   end else begin : g_wsingle
      assign width_done = 1'b1;
   end

   assign busy = (state != SEQ_IDLE);
   assign fire = (state == SEQ_FIRE);
endmodule

// File: rtl/trig_delay_unit.sv
module trig_delay_unit #(
   parameter int DATA_W      = 8,
   parameter int DLY_W       = 24,
   parameter int PULSE_W     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int LANES      = DLY_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_in,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              load_stb,
   input  logic [LANES-1:0]  byte_sel,
   output logic              pulse_out,
   output logic              busy
);
   if (DLY_W % DATA_W != 0) begin : g_bad_width
      $error("DLY_W must be a multiple of DATA_W");
   end
   if (PULSE_W < 1) begin : g_bad_pulse
      $error("PULSE_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             sync_pls;
   logic [DLY_W-1:0] delay_word;

   tdl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_in),
      .rise_pls (sync_pls)
   );

   tdl_delay_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (bus_data),
      .wr_en    (load_stb),
      .lane_sel (byte_sel),
      .word     (delay_word)
   );

   tdl_sequencer #(.DLY_W(DLY_W), .PULSE_W(PULSE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sync_pls),
      .dly_value (delay_word),
      .busy      (busy),
      .fire      (pulse_out)
   );
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
   parameter int DLY_W   = 24,
   parameter int PULSE_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_pls,
   input logic [DLY_W-1:0] delay_word,
   input logic             busy,
   input logic             pulse_out
);
   logic [31:0] hi_cnt;
   logic [1:0]  rise_cnt;
   logic        out_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         rise_cnt <= '0;
         out_d    <= 1'b0;
      end else begin
         out_d  <= pulse_out;
         hi_cnt <= pulse_out ? hi_cnt + 1 : '0;
         if (!busy)                               rise_cnt <= '0;
         else if (pulse_out && !out_d && rise_cnt != 2'd3) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R1: the start pulse lasts a single cycle
   a_r1_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pls |=> !sync_pls);

   // R2: a start while idle raises busy on the next edge
   a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pls && !busy) |=> busy);

   // R2: busy ends together with the pulse
   a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(pulse_out));

   // R3: pulse width equals PULSE_W
   a_r3_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_out) |-> (hi_cnt == 32'(PULSE_W)));

   // R4: a zero delay fires right after the start
   a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pls && !busy && delay_word == '0) |=> pulse_out);

   // R7: at most one pulse per busy window
   a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rise_cnt <= 2'd1));
endmodule

bind trig_delay_unit tdl_checker #(.DLY_W(DLY_W), .PULSE_W(PULSE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_pls   (sync_pls),
   .delay_word (delay_word),
   .busy       (busy),
   .pulse_out  (pulse_out)
);

// File: tb/sim_trig_delay_unit.sv
module sim_trig_delay_unit;
   localparam int CLK_PERIOD = 10;
   localparam int PW         = 4;
   localparam int NVEC       = 7;
   localparam logic [23:0] VEC_DLY [NVEC] = '{24'd0, 24'd1, 24'd2, 24'd5,
                                              24'd17, 24'd255, 24'd300};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_in = 1'b0;
   logic [7:0] bus_data = '0;
   logic       load_stb = 1'b0;
   logic [2:0] byte_sel = '0;
   logic       pulse_out, busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_delay_unit u0 (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bus_data(bus_data),
      .load_stb(load_stb), .byte_sel(byte_sel), .pulse_out(pulse_out), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_byte(input int lane, input logic [7:0] val);
      @(negedge clk);
      bus_data = val; byte_sel = 3'(1 << lane); load_stb = 1'b1;
      @(negedge clk);
      load_stb = 1'b0; byte_sel = '0; bus_data = '0;
   endtask

   task automatic program_delay(input logic [23:0] d);
      for (int i = 0; i < 3; i++) write_byte(i, d[i*8 +: 8]);
   endtask

   // act: 0 none, 1 retrigger pulse at act_at, 2 write low byte at act_at
   task automatic fire_and_check(input int exp_lat, input int act, input int act_at,
                                 input logic [7:0] act_val, input string req);
      int n = 0;
      int hi = 0;
      int stray = 0;
      bit seen = 1'b0;
      bit b2 = 1'b1;
      bit b3 = 1'b0;
      @(negedge clk);
      trig_in = 1'b1;
      while (!seen && n < exp_lat + 20) begin
         @(negedge clk);
         n++;
         if (n == 2) b2 = busy;
         if (n == 3) b3 = busy;
         if (pulse_out) seen = 1'b1;
         if (act == 1 && n == act_at)     trig_in = 1'b0;
         if (act == 1 && n == act_at + 1) trig_in = 1'b1;
         if (act == 2 && n == act_at) begin
            bus_data = act_val; byte_sel = 3'b001; load_stb = 1'b1;
         end
         if (act == 2 && n == act_at + 1) begin
            load_stb = 1'b0; byte_sel = '0; bus_data = '0;
         end
      end
      check(seen && (n - 1) == exp_lat, req, "latency", n - 1, exp_lat);
      check(b2 == 1'b0 && b3 == 1'b1, "R2", "busy rise (b2,b3)", {b2, b3}, 1);
      while (pulse_out && hi < PW + 5) begin
         hi++;
         @(negedge clk);
      end
      check(hi == PW, "R3", "pulse width", hi, PW);
      check(busy == 1'b0, "R2", "busy after pulse", busy, 0);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (pulse_out) stray++;
      end
      check(stray == 0, (act == 1) ? "R7" : "R10", "extra pulse cycles", stray, 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      check(pulse_out == 1'b0, "R9", "pulse_out in reset", pulse_out, 0);
      check(busy == 1'b0, "R9", "busy in reset", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pulse_out == 1'b0 && busy == 1'b0, "R9", "outputs after reset", {pulse_out, busy}, 0);
      // R9, R4: unprogrammed word is zero, minimum latency
      fire_and_check(2, 0, 0, 8'h00, "R9");

      // R1: table of delays
      for (int v = 0; v < NVEC; v++) begin
         program_delay(VEC_DLY[v]);
         fire_and_check(int'(VEC_DLY[v]) + 2, 0, 0, 8'h00, (VEC_DLY[v] == 0) ? "R4" : "R1");
      end

      // R5: middle and high byte positions
      program_delay(24'h000200);
      fire_and_check(512 + 2, 0, 0, 8'h00, "R5");
      program_delay(24'h010000);
      fire_and_check(65536 + 2, 0, 0, 8'h00, "R5");

      // R6: writes without load_stb are dropped
      program_delay(24'd9);
      @(negedge clk);
      bus_data = 8'h55; byte_sel = 3'b111; load_stb = 1'b0;
      repeat (3) @(negedge clk);
      byte_sel = '0; bus_data = '0;
      fire_and_check(11, 0, 0, 8'h00, "R6");

      // R7: retrigger while busy is ignored
      program_delay(24'd20);
      fire_and_check(22, 1, 6, 8'h00, "R7");

      // R8: write during busy applies to the next sequence only
      program_delay(24'd10);
      fire_and_check(12, 2, 4, 8'd3, "R8");
      fire_and_check(5, 0, 0, 8'h00, "R8");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule